// File: doc/BRIEF.md
# Snoop Bus Hold and Inquire Controller

This block is the system-side agent that takes the processor bus away so that an inquire (snoop) cycle can be run against the processor's cache. When a snoop request arrives, the block asserts a hold request toward the processor. If the processor is starting a bus cycle in that same clock, the block also issues a short back-off pulse. The block drives the snoop address and the external address strobe only once the processor has shown, through its hold acknowledge, that it has let go of the bus.

The block never assumes a fixed acknowledge latency. Some processors acknowledge one clock after they see the hold request and others take two clocks or more. The block waits until the acknowledge is sampled high and the processor's drive indication is low. It then drives the address and the strobe together for exactly one clock and releases the hold request. It reports completion only after the acknowledge has dropped again. A separate output flags any clock in which the block and the processor both drive the address bus.

Top module: `snoop_hold_ctrl`

## Requirements
- R1: After reset, hold_o, boff_o, bus_drv_o, eads_o, done_o and contend_o are 0 and addr_o is all zeros.
- R2: A snp_req_i sampled high while idle makes hold_o high from the next clock. snp_addr_i is captured at that edge. hold_o stays high until the clock after the strobe.
- R3: If cpu_ads_i is high at the edge where a request is accepted, boff_o is high for exactly BOFF_CYCLES clocks (1 or 2), starting in the next clock. Otherwise boff_o stays low.
- R4: bus_drv_o rises only in the clock after an edge where cpu_hlda_i was sampled 1 and cpu_drv_i was sampled 0. This holds for any acknowledge latency.
- R5: eads_o is high for exactly one clock per accepted request. In that clock bus_drv_o is high and addr_o equals the captured address.
- R6: After the strobe, done_o pulses high for one clock. The pulse follows the first edge at which cpu_hlda_i is sampled 0. The block is then idle.
- R7: snp_req_i pulses that arrive while a snoop is in progress are ignored, so one accepted request yields exactly one strobe.
- R8: contend_o is high in any clock in which bus_drv_o and cpu_drv_i are both 1, and low otherwise.
- R9: addr_o is all zeros whenever bus_drv_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snp_req_i | input | 1 | Snoop request, accepted only when idle |
| snp_addr_i | input | ADDR_W | Snoop address, captured when the request is accepted |
| cpu_ads_i | input | 1 | Processor address strobe (bus cycle starting) |
| cpu_hlda_i | input | 1 | Processor hold acknowledge |
| cpu_drv_i | input | 1 | Processor is driving the address bus |
| hold_o | output | 1 | Hold request to the processor |
| boff_o | output | 1 | Back-off pulse to the processor |
| bus_drv_o | output | 1 | Enable for this block's address drivers |
| addr_o | output | ADDR_W | Snoop address, zero when not driving |
| eads_o | output | 1 | External address strobe for the inquire cycle |
| done_o | output | 1 | One-clock completion pulse |
| contend_o | output | 1 | Both sides driving the address bus |

## Verification
The bench builds the block with BOFF_CYCLES=2 and ADDR_W=16, so the two-clock back-off counter variant is the one under test. Its processor responder model changes its acknowledge latency at run time between 1, 2 and 3 clocks. This covers both the prompt processor and the late one, plus a slower case beyond them. Requests are issued both with and without a coinciding address strobe, extra requests are fired during a snoop in progress, and a misbehaving responder that drives the bus during the strobe clock is used to make the contention flag fire.

// File: rtl/snp_pkg.sv
package snp_pkg;
   typedef enum logic [1:0] {
      SN_IDLE  = 2'd0,
      SN_WAIT  = 2'd1,
      SN_DRIVE = 2'd2,
      SN_FREE  = 2'd3
   } snp_state_e;

   localparam int unsigned SNP_BOFF_MAX = 2;
endpackage

// File: rtl/snp_boff_gen.sv
module snp_boff_gen #(
   parameter int unsigned LEN = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire_i,
   output logic boff_o
);
   if (LEN < 1 || LEN > snp_pkg::SNP_BOFF_MAX) begin : g_bad_len
      $error("snp_boff_gen: LEN must be 1 or 2");
   end

   if (LEN == 1) begin : g_one
      logic boff_q;
      always_ff @(posedge clk) begin
         if (!rst_n) boff_q <= 1'b0;
         else        boff_q <= fire_i;
      end
      assign boff_o = boff_q;

      p_boff_single_r3 : assert property (@(posedge clk) disable iff (!rst_n)
         boff_o |=> !boff_o);
   end else begin : g_multi
      localparam int unsigned CW = $clog2(LEN + 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
         if (!rst_n)              cnt_q <= '0;
         else if (fire_i)         cnt_q <= CW'(LEN);
         else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
      end
      assign boff_o = (cnt_q != '0);

      p_boff_double_r3 : assert property (@(posedge clk) disable iff (!rst_n)
         $rose(boff_o) |=> boff_o ##1 !boff_o);
   end

   p_boff_after_fire_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(boff_o) |-> $past(fire_i));
endmodule

// File: rtl/snp_seq.sv
module snp_seq
   import snp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_i,
   input  logic       hlda_i,
   input  logic       cpu_drv_i,
   output logic       accept_o,
   output logic       hold_o,
   output logic       drive_o,
   output logic       done_o
);
   snp_state_e state_q, state_d;
   logic       done_q;

   assign accept_o = (state_q == SN_IDLE) && req_i;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SN_IDLE:  if (req_i)                state_d = SN_WAIT;
         SN_WAIT:  if (hlda_i && !cpu_drv_i) state_d = SN_DRIVE;
         SN_DRIVE:                           state_d = SN_FREE;
         SN_FREE:  if (!hlda_i)              state_d = SN_IDLE;
         default:                            state_d = SN_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SN_IDLE;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= (state_q == SN_FREE) && !hlda_i;
      end
   end

   assign hold_o  = (state_q == SN_WAIT) || (state_q == SN_DRIVE);
   assign drive_o = (state_q == SN_DRIVE);
   assign done_o  = done_q;

   p_drive_after_hlda_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drive_o) |-> $past(hlda_i) && !$past(cpu_drv_i));

   p_drive_one_clk_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      drive_o |=> !drive_o && !hold_o);

   p_done_after_release_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !$past(hlda_i) && !hold_o);

   p_hold_drops_after_strobe_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hold_o) |-> $past(drive_o));
endmodule

// File: rtl/snp_addr_hold.sv
module snp_addr_hold #(
   parameter int unsigned ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              drive_i,
   output logic [ADDR_W-1:0] addr_o
);
   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      addr_q <= '0;
      else if (load_i) addr_q <= addr_i;
   end

   assign addr_o = drive_i ? addr_q : '0;

   p_addr_stable_in_drive_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      drive_i |-> $stable(addr_q));
endmodule

// File: rtl/snoop_hold_ctrl.sv
module snoop_hold_ctrl #(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned BOFF_CYCLES = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              snp_req_i,
   input  logic [ADDR_W-1:0] snp_addr_i,
   input  logic              cpu_ads_i,
   input  logic              cpu_hlda_i,
   input  logic              cpu_drv_i,
   output logic              hold_o,
   output logic              boff_o,
   output logic              bus_drv_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              eads_o,
   output logic              done_o,
   output logic              contend_o
);
   if (ADDR_W < 1) begin : g_bad_aw
      $error("snoop_hold_ctrl: ADDR_W must be at least 1");
   end

   logic accept;
   logic drive;

   snp_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_i     (snp_req_i),
      .hlda_i    (cpu_hlda_i),
      .cpu_drv_i (cpu_drv_i),
      .accept_o  (accept),
      .hold_o    (hold_o),
      .drive_o   (drive),
      .done_o    (done_o)
   );

   snp_boff_gen #(.LEN(BOFF_CYCLES)) u_boff (
      .clk    (clk),
      .rst_n  (rst_n),
      .fire_i (accept && cpu_ads_i),
      .boff_o (boff_o)
   );

   snp_addr_hold #(.ADDR_W(ADDR_W)) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (accept),
      .addr_i  (snp_addr_i),
      .drive_i (drive),
      .addr_o  (addr_o)
   );

   assign bus_drv_o = drive;
   assign eads_o    = drive;
   assign contend_o = drive && cpu_drv_i;

   p_strobe_needs_ack_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      eads_o |-> $past(cpu_hlda_i) && $past(hold_o));

   p_hold_rise_on_req_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold_o) |-> $past(snp_req_i));

   p_no_boff_when_drive_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      bus_drv_o |-> !boff_o);
endmodule

// File: tb/tb_snoop_hold_ctrl.sv
module tb_snoop_hold_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 16;
   localparam int BOFF = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic snp_req = 1'b0;
   logic [AW-1:0] snp_addr = '0;
   logic cpu_ads = 1'b0;
   logic cpu_hlda = 1'b0;
   logic cpu_drv;
   logic hold, boff, bus_drv, eads, done, contend;
   logic [AW-1:0] addr;

   int lat = 1;
   logic rogue = 1'b0;
   int hcnt = 0;

   int vectors = 0;
   int fails = 0;
   int cycles = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   // processor responder: releases the bus when it acknowledges
   assign cpu_drv = !cpu_hlda || (rogue && bus_drv);

   always @(posedge clk) begin
      if (!rst_n || !hold) begin
         hcnt <= 0;
         if (!rst_n) cpu_hlda <= 1'b0;
         else        cpu_hlda <= 1'b0;
      end else begin
         if (hcnt + 1 >= lat) cpu_hlda <= 1'b1;
         hcnt <= hcnt + 1;
      end
   end

   snoop_hold_ctrl #(.ADDR_W(AW), .BOFF_CYCLES(BOFF)) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .snp_req_i  (snp_req),
      .snp_addr_i (snp_addr),
      .cpu_ads_i  (cpu_ads),
      .cpu_hlda_i (cpu_hlda),
      .cpu_drv_i  (cpu_drv),
      .hold_o     (hold),
      .boff_o     (boff),
      .bus_drv_o  (bus_drv),
      .addr_o     (addr),
      .eads_o     (eads),
      .done_o     (done),
      .contend_o  (contend)
   );

   // behavioural reference: 0 idle, 1 awaiting ack, 2 strobe, 3 awaiting release
   int m_st = 0;
   int m_bcnt = 0;
   logic m_done = 1'b0;
   logic [AW-1:0] m_addr = '0;
   int eads_count = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st <= 0; m_bcnt <= 0; m_done <= 1'b0; m_addr <= '0;
      end else begin
         m_done <= (m_st == 3) && !cpu_hlda;
         if (m_st == 0 && snp_req && cpu_ads) m_bcnt <= BOFF;
         else if (m_bcnt > 0)                 m_bcnt <= m_bcnt - 1;
         case (m_st)
            0: if (snp_req) begin m_st <= 1; m_addr <= snp_addr; end
            1: if (cpu_hlda && !cpu_drv) m_st <= 2;
            2: m_st <= 3;
            default: if (!cpu_hlda) m_st <= 0;
         endcase
      end
   end

   task automatic cmp1(input string tag, input string name, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", tag, name, act, exp, cycles);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         logic exp_drv;
         exp_drv = (m_st == 2);
         vectors++;
         cmp1("R2", "hold",    AW'(hold),    AW'(m_st == 1 || m_st == 2));
         cmp1("R3", "boff",    AW'(boff),    AW'(m_bcnt != 0));
         cmp1("R4", "bus_drv", AW'(bus_drv), AW'(exp_drv));
         cmp1("R5", "eads",    AW'(eads),    AW'(exp_drv));
         cmp1("R6", "done",    AW'(done),    AW'(m_done));
         cmp1("R9", "addr",    addr,         exp_drv ? m_addr : '0);
         cmp1("R8", "contend", AW'(contend), AW'(exp_drv && cpu_drv));
         if (eads) eads_count++;
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   task automatic snoop(input int l, input logic ads, input logic [AW-1:0] a,
                        input logic extra_req);
      lat = l;
      @(negedge clk);
      eads_count = 0;
      snp_req = 1'b1; snp_addr = a; cpu_ads = ads;
      @(negedge clk);
      snp_req = 1'b0; cpu_ads = 1'b0; snp_addr = ~a;
      if (extra_req) begin
         snp_req = 1'b1;           // R7: arrives while busy
         @(negedge clk);
         snp_req = 1'b0;
      end
      while (!done) @(negedge clk);
      vectors++;
      if (eads_count != 1) begin
         fails++;
         $display("FAIL R7 strobes per request: actual %0d expected 1", eads_count);
      end
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset values while reset is held
      vectors++;
      if ({hold, boff, bus_drv, eads, done, contend} !== 6'b0 || addr !== '0) begin
         fails++;
         $display("FAIL R1 reset outputs: actual %b/%0h expected 0/0",
                  {hold, boff, bus_drv, eads, done, contend}, addr);
      end
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      snoop(1, 1'b0, 16'h1234, 1'b0);   // prompt acknowledge, no back-off
      snoop(1, 1'b1, 16'hBEEF, 1'b0);   // R3 back-off with cycle starting
      snoop(2, 1'b1, 16'h0F0F, 1'b0);   // R4 late acknowledge
      snoop(3, 1'b0, 16'hA5A5, 1'b1);   // R7 extra request while busy
      snoop(2, 1'b0, 16'hFFFF, 1'b1);
      // R8: misbehaving processor drives during the strobe clock
      rogue = 1'b1;
      lat = 1;
      @(negedge clk);
      snp_req = 1'b1; snp_addr = 16'h0001;
      @(negedge clk);
      snp_req = 1'b0;
      while (!bus_drv) @(negedge clk);
      vectors++;
      if (contend !== 1'b1) begin
         fails++;
         $display("FAIL R8 contention flag: actual %b expected 1", contend);
      end
      while (!done) @(negedge clk);
      rogue = 1'b0;
      repeat (3) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule